// File: doc/BRIEF.md
# Register-Controlled GPIO Port with Edge Capture

This block is a general-purpose I/O port of up to 32 pins, controlled from a small synchronous register bus. The bus has an address, a write strobe with write data, and a read strobe with registered read data. Software sets the value each pin drives and chooses which pins drive at all. It reads back the levels present on the pins and selects which pins may raise the single combined interrupt line.

Pin inputs are resynchronised before use. The trigger type is chosen when the block is built. In rising, falling or both-edge mode, each detected event latches a per-pin capture bit, and the bit stays set until software writes a 1 to it. In level-high mode the interrupt follows the synchronised pin levels gated by the enable mask, and the capture register stays empty. Pad buffers sit outside the block and are fed from the output-enable and output-value ports.

Top module: `pio_edge_port`

## Requirements
- R1: After reset the direction, output-value, enable-mask and capture registers are all zero, every `pin_oe` bit is 0, `irq` is 0 and `bus_rdata` is 0.
- R2: Offset 0x4 holds the direction register. A bit of 1 makes that pin an output (`pin_oe` bit 1) and a bit of 0 makes it an input. The register reads back what was written.
- R3: A write to offset 0x0 sets the output-value register, which drives `pin_out`. A read of offset 0x0 returns the pin levels after a two-flop synchroniser, with bit n for pin n, and never the output-value register.
- R4: Register bits at positions PIN_COUNT and above read as 0 and ignore writes.
- R5: Read data appears on `bus_rdata` in the cycle after the read strobe and is 0 in other cycles. The mapped offsets are 0x0, 0x4, 0x8 and 0xC, decoded on the full address, and every other address reads 0.
- R6: In edge modes, an event on a synchronised pin sets its capture bit (offset 0xC), and the bit then stays set. TRIG encoding: 0 = rising (0 to 1), 1 = falling (1 to 0), 2 = either change, 3 = level high.
- R7: Writing 1 to a capture bit clears it. Writing 0 leaves it unchanged.
- R8: When a new event and a write-1 clear hit the same capture bit in the same cycle, the bit ends set.
- R9: In edge modes, `irq` is the OR over all pins of capture AND mask. A pin change that arrives before clock edge 1 is reflected on `irq` after edge 3.
- R10: In level-high mode, `irq` is the OR over all pins of the synchronised level AND mask. It rises after edge 2 following the pin change, and the capture register reads 0.
- R11: Offset 0x8 holds the enable mask and reads back what was written. A 1 enables that pin's interrupt and a 0 blocks it, even when its capture bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_in | input | PIN_COUNT | Levels sampled from the pins |
| pin_oe | output | PIN_COUNT | Per-pin drive enable |
| pin_out | output | PIN_COUNT | Per-pin driven value |
| irq | output | 1 | Combined interrupt request |

## Verification
A software clear of a capture bit and a fresh hardware event on that same bit can land on the same clock edge. The bench provokes this by timing the change on the pin so that its synchronised edge is detected in exactly the cycle that carries a write-1 to the capture offset. The same write also clears a second bit that has no new event. The bench then reads the register back and requires the colliding bit to be set and the idle bit to be cleared, for both the either-change and falling-edge builds.

// File: rtl/pio_pkg.sv
package pio_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [1:0] {
        TRIG_RISE  = 2'd0,
        TRIG_FALL  = 2'd1,
        TRIG_BOTH  = 2'd2,
        TRIG_LEVEL = 2'd3
    } trig_e;

    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_DIR  = 8'h04;
    localparam logic [7:0] OFS_MASK = 8'h08;
    localparam logic [7:0] OFS_CAP  = 8'h0C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_MASK,
        SEL_CAP
    } sel_e;

endpackage

// File: rtl/pio_addr_decode.sv
module pio_addr_decode #(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output pio_pkg::sel_e     sel
);
    import pio_pkg::*;

    always_comb begin
        if (addr == ADDR_W'(OFS_DATA))      sel = SEL_DATA;
        else if (addr == ADDR_W'(OFS_DIR))  sel = SEL_DIR;
        else if (addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
        else if (addr == ADDR_W'(OFS_CAP))  sel = SEL_CAP;
        else                                sel = SEL_NONE;
    end

endmodule

// File: rtl/pio_sync.sv
module pio_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw,
    output logic [N-1:0] synced
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign synced = st_q.s2;

endmodule

// File: rtl/pio_edge_detect.sv
module pio_edge_detect #(
    parameter int             N    = 32,
    parameter pio_pkg::trig_e TRIG = pio_pkg::TRIG_RISE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] evt
);
    import pio_pkg::*;

    typedef struct packed {
        logic [N-1:0] prev;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (TRIG == TRIG_RISE) begin : g_rise
            assign evt = lvl & ~st_q.prev;
        end else if (TRIG == TRIG_FALL) begin : g_fall
            assign evt = ~lvl & st_q.prev;
        end else begin : g_both
            assign evt = lvl ^ st_q.prev;
        end
    endgenerate

endmodule

// File: rtl/pio_capture.sv
module pio_capture #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] cap
);

    typedef struct packed {
        logic [N-1:0] bits;
    } cap_t;

    cap_t st_d, st_q;
    logic [N-1:0] clr_mask;

    always_comb begin
        clr_mask  = clr_en ? clr_bits : '0;
        st_d      = st_q;
        // a new event is ORed in after the clear so it is never lost
        st_d.bits = (st_q.bits & ~clr_mask) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap = st_q.bits;

endmodule

// File: rtl/pio_edge_port.sv
module pio_edge_port #(
    parameter int             PIN_COUNT = 32,
    parameter int             ADDR_W    = 4,
    parameter pio_pkg::trig_e TRIG      = pio_pkg::TRIG_RISE
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [31:0]           bus_wdata,
    input  logic                  bus_rd,
    output logic [31:0]           bus_rdata,
    input  logic [PIN_COUNT-1:0]  pin_in,
    output logic [PIN_COUNT-1:0]  pin_oe,
    output logic [PIN_COUNT-1:0]  pin_out,
    output logic                  irq
);
    import pio_pkg::*;

    localparam int N = PIN_COUNT;
    localparam bit EDGE_MODE = (TRIG != TRIG_LEVEL);

    typedef struct packed {
        logic [N-1:0]     outv;
        logic [N-1:0]     dir;
        logic [N-1:0]     mask;
        logic [BUS_W-1:0] rdata;
    } regs_t;

    regs_t st_d, st_q;

    sel_e         sel;
    logic [N-1:0] pin_sync;
    logic [N-1:0] cap_q;
    logic [N-1:0] mask_q;
    logic [N-1:0] wbits;
    logic         cap_wr;

    pio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    pio_sync #(.N(N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .synced (pin_sync)
    );

    assign wbits  = bus_wdata[N-1:0];
    assign cap_wr = bus_wr && (sel == SEL_CAP);

    generate
        if (EDGE_MODE) begin : g_edge
            logic [N-1:0] evt;

            pio_edge_detect #(.N(N), .TRIG(TRIG)) u_det (
                .clk   (clk),
                .rst_n (rst_n),
                .lvl   (pin_sync),
                .evt   (evt)
            );

            pio_capture #(.N(N)) u_cap (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt      (evt),
                .clr_en   (cap_wr),
                .clr_bits (wbits),
                .cap      (cap_q)
            );

            assign irq = |(cap_q & mask_q);
        end else begin : g_level
            assign cap_q = '0;
            assign irq   = |(pin_sync & mask_q);
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;

        if (bus_wr) begin
            case (sel)
                SEL_DATA: st_d.outv = wbits;
                SEL_DIR:  st_d.dir  = wbits;
                SEL_MASK: st_d.mask = wbits;
                default:  ;
            endcase
        end

        if (bus_rd) begin
            case (sel)
                SEL_DATA: st_d.rdata[N-1:0] = pin_sync;
                SEL_DIR:  st_d.rdata[N-1:0] = st_q.dir;
                SEL_MASK: st_d.rdata[N-1:0] = st_q.mask;
                SEL_CAP:  st_d.rdata[N-1:0] = cap_q;
                default:  st_d.rdata        = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_q    = st_q.mask;
    assign pin_oe    = st_q.dir;
    assign pin_out   = st_q.outv;
    assign bus_rdata = st_q.rdata;

endmodule

// File: rtl/pio_edge_port_chk.sv
module pio_edge_port_chk #(
    parameter int             PIN_COUNT = 32,
    parameter int             ADDR_W    = 4,
    parameter pio_pkg::trig_e TRIG      = pio_pkg::TRIG_RISE
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [31:0]          bus_rdata,
    input logic [PIN_COUNT-1:0] pin_oe,
    input logic [PIN_COUNT-1:0] cap_q,
    input logic [PIN_COUNT-1:0] mask_q,
    input logic                 irq
);
    import pio_pkg::*;

    logic mapped;
    assign mapped = (bus_addr == ADDR_W'(OFS_DATA)) || (bus_addr == ADDR_W'(OFS_DIR)) ||
                    (bus_addr == ADDR_W'(OFS_MASK)) || (bus_addr == ADDR_W'(OFS_CAP));

    assert_oe_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFS_DIR)) |=> $stable(pin_oe));

    assert_unmapped_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |=> (bus_rdata == 32'h0));

    assert_idle_rdata_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == 32'h0));

    assert_cap_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFS_CAP)) |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

    assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0));

    generate
        if (PIN_COUNT < 32) begin : g_upper
            assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
                bus_rdata[31:PIN_COUNT] == '0);
        end
        if (TRIG == TRIG_LEVEL) begin : g_lvl
            assert_level_cap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
                cap_q == '0);
        end
    endgenerate

endmodule

bind pio_edge_port pio_edge_port_chk #(
    .PIN_COUNT (PIN_COUNT),
    .ADDR_W    (ADDR_W),
    .TRIG      (TRIG)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .cap_q     (cap_q),
    .mask_q    (mask_q),
    .irq       (irq)
);

// File: tb/pio_edge_port_tb_top.sv
module pio_edge_port_tb_top;
    import pio_pkg::*;

    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_rd = 1'b0;
    logic [NP-1:0] pin_in = '0;

    logic [31:0]   rdata [4];
    logic [NP-1:0] oe    [4];
    logic [NP-1:0] outv  [4];
    logic          irqv  [4];
    logic [31:0]   rv    [4];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pio_edge_port #(.PIN_COUNT(NP), .ADDR_W(4), .TRIG(TRIG_RISE)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(rdata[0]), .pin_in(pin_in), .pin_oe(oe[0]),
        .pin_out(outv[0]), .irq(irqv[0]));
    pio_edge_port #(.PIN_COUNT(NP), .ADDR_W(4), .TRIG(TRIG_FALL)) dut_fall_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(rdata[1]), .pin_in(pin_in), .pin_oe(oe[1]),
        .pin_out(outv[1]), .irq(irqv[1]));
    pio_edge_port #(.PIN_COUNT(NP), .ADDR_W(4), .TRIG(TRIG_BOTH)) dut_both_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(rdata[2]), .pin_in(pin_in), .pin_oe(oe[2]),
        .pin_out(outv[2]), .irq(irqv[2]));
    pio_edge_port #(.PIN_COUNT(NP), .ADDR_W(4), .TRIG(TRIG_LEVEL)) dut_lvl_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(rdata[3]), .pin_in(pin_in), .pin_oe(oe[3]),
        .pin_out(outv[3]), .irq(irqv[3]));

    // {pin pattern, expected rising-edge capture after clearing}
    localparam logic [47:0] VEC [5] = '{
        {24'h0000FF, 24'h0000FF},
        {24'h00F0F0, 24'h00F000},
        {24'hFFFFFF, 24'hFF0F0F},
        {24'h123456, 24'h000000},
        {24'hABCDEF, 24'hA9C9A9}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge, returns at a falling edge
    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
        for (int k = 0; k < 4; k++) rv[k] = rdata[k];
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rdata", rdata[0], 32'h0);
        chk("R1 pin_oe", {8'h0, oe[0]}, 32'h0);
        chk("R1 irq", {31'h0, irqv[0]}, 32'h0);
        bus_read(4'h4); chk("R1 dir", rv[0], 32'h0);
        bus_read(4'h8); chk("R1 mask", rv[0], 32'h0);
        bus_read(4'hC); chk("R1 cap", rv[0], 32'h0);
        chk("R5 rdata idle after read", rdata[0], 32'h0);

        // R2 direction, R4 upper bits
        bus_write(4'h4, 32'hFFFF_FFFF);
        chk("R2 pin_oe all", {8'h0, oe[0]}, 32'h00FF_FFFF);
        bus_read(4'h4); chk("R4 dir upper bits", rv[0], 32'h00FF_FFFF);
        bus_write(4'h4, 32'h0000_F00F);
        chk("R2 pin_oe pattern", {8'h0, oe[0]}, 32'h0000_F00F);
        bus_read(4'h4); chk("R2 dir readback", rv[0], 32'h0000_F00F);

        // R3 data write drives pin_out, read returns pins
        bus_write(4'h0, 32'h5A5A_5A5A);
        chk("R3 pin_out", {8'h0, outv[0]}, 32'h005A_5A5A);
        pin_in = 24'h13579B;
        idle(3);
        bus_read(4'h0); chk("R3 data read is pin level", rv[0], 32'h0013_579B);

        // R5 unmapped offsets
        bus_read(4'h2); chk("R5 unmapped 0x2", rv[0], 32'h0);
        bus_read(4'h6); chk("R5 unmapped 0x6", rv[0], 32'h0);
        bus_read(4'hF); chk("R5 unmapped 0xF", rv[0], 32'h0);

        // R6 table of pin patterns across edge modes
        pin_in = '0;
        idle(4);
        prev = '0;
        for (int i = 0; i < 5; i++) begin
            bus_write(4'hC, 32'hFFFF_FFFF);
            pin_in = VEC[i][47:24];
            idle(4);
            bus_read(4'hC);
            chk("R6 rising capture", rv[0], {8'h0, VEC[i][23:0]});
            chk("R6 falling capture", rv[1], {8'h0, prev & ~VEC[i][47:24]});
            chk("R6 both capture", rv[2], {8'h0, prev ^ VEC[i][47:24]});
            chk("R10 level capture zero", rv[3], 32'h0);
            prev = VEC[i][47:24];
        end

        // R8 set wins over same-cycle clear
        bus_write(4'hC, 32'hFFFF_FFFF);
        pin_in = 24'hABCDEB;
        idle(4);
        bus_read(4'hC);
        chk("R6 both bit2 set", rv[2] & 32'h6, 32'h4);
        pin_in = 24'hABCDE9;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_write(4'hC, 32'h0000_0006);
        bus_read(4'hC);
        chk("R8 both collide", rv[2] & 32'h6, 32'h2);
        chk("R8 fall collide", rv[1] & 32'h6, 32'h2);
        chk("R7 rise cleared", rv[0] & 32'h6, 32'h0);

        // R9 / R11 / R7 interrupt path
        bus_write(4'hC, 32'hFFFF_FFFF);
        pin_in = '0;
        idle(4);
        bus_write(4'hC, 32'hFFFF_FFFF);
        bus_write(4'h8, 32'h0000_0001);
        bus_read(4'h8); chk("R11 mask readback", rv[0], 32'h1);
        pin_in = 24'h000001;
        @(negedge clk);
        chk("R10 level irq before edge 2", {31'h0, irqv[3]}, 32'h0);
        @(negedge clk);
        chk("R9 irq low after edge 2", {31'h0, irqv[0]}, 32'h0);
        chk("R10 level irq after edge 2", {31'h0, irqv[3]}, 32'h1);
        @(negedge clk);
        chk("R9 irq high after edge 3", {31'h0, irqv[0]}, 32'h1);
        chk("R9 fall irq quiet", {31'h0, irqv[1]}, 32'h0);
        bus_write(4'hC, 32'h0000_0000);
        chk("R7 write 0 keeps irq", {31'h0, irqv[0]}, 32'h1);
        bus_read(4'hC); chk("R7 write 0 keeps bit", rv[0], 32'h1);
        bus_write(4'hC, 32'h0000_0001);
        chk("R7 write 1 drops irq", {31'h0, irqv[0]}, 32'h0);
        bus_read(4'hC); chk("R7 write 1 clears bit", rv[0], 32'h0);
        pin_in = 24'h000003;
        idle(4);
        chk("R11 masked pin no irq", {31'h0, irqv[0]}, 32'h0);
        bus_read(4'hC); chk("R11 masked pin still captured", rv[0], 32'h2);
        chk("R10 level irq follows pin", {31'h0, irqv[3]}, 32'h1);
        pin_in = 24'h000002;
        idle(4);
        chk("R10 level irq drops", {31'h0, irqv[3]}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule